// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block takes a three-wire serial stream (serial clock, serial data, load enable) and turns it into the divide settings and control flags for a frequency synthesizer. A 19-bit shift chain collects one bit on every rising edge of the serial clock, most significant bit first. A rising edge on load enable then copies the word into one of two holding registers. The last bit shifted in chooses the register: high selects the reference register, low selects the divider register.

The reference register holds a 14-bit reference ratio and three flags: prescaler modulus select, phase polarity, and lock/monitor output select. The divider register holds a 7-bit swallow count and an 11-bit main count. The three serial inputs are asynchronous to the system clock, so each one passes through a synchronizer before its edges are detected.

A load that carries a reference ratio or main count below 5 is refused. The target register keeps its old contents and a configuration error flag is raised. The next accepted load clears the flag.

Top module: `synth_serial_loader`

## Requirements
- R1: On each rising edge of `ser_clk_i`, the level of `ser_data_i` is shifted into the chain. Bits are sent most significant first, and the 19th bit sent is the destination bit (word bit 0).
- R2: The registers update only on a rising edge of `ser_load_i`. Holding load enable high while more bits are shifted in changes nothing until the next rising edge.
- R3: When the destination bit is 1, the word loads the reference register with these fields: ratio = word bits 14..1, prescaler select = bit 15, phase polarity = bit 16, output select = bit 17.
- R4: When the destination bit is 0, the word loads the divider register with these fields: swallow count = word bits 7..1, main count = word bits 18..8.
- R5: A load aimed at one register leaves every field of the other register unchanged.
- R6: Reset (`rst_ni` low) sets the reference ratio to 5, the main count to 5, the swallow count to 0, all three flags to 0 and the error flag to 0.
- R7: A reference load whose ratio is below 5 changes no field of the reference register and sets `cfg_err_o`. A ratio of exactly 5 is accepted.
- R8: A divider load whose main count is below 5 changes neither the main count nor the swallow count and sets `cfg_err_o`. Full-scale values (main 2047, swallow 127) and the minimum (main 5, swallow 0) are accepted.
- R9: Any accepted load clears `cfg_err_o`, and the flag rises only as a result of a load.
- R10: When more than 19 bits are shifted in before a load, only the last 19 bits count.
- R11: Word bit 18 of a reference word has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock; the chain shifts on its rising edge |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_load_i | input | 1 | Load enable; its rising edge transfers the word |
| ref_div_o | output | 14 | Latched reference ratio |
| psc_sel_o | output | 1 | Latched prescaler modulus select |
| phase_inv_o | output | 1 | Latched phase polarity flag |
| mon_sel_o | output | 1 | Latched lock/monitor output select |
| swallow_o | output | 7 | Latched swallow count |
| main_div_o | output | 11 | Latched main count |
| cfg_err_o | output | 1 | Set by a refused load, cleared by an accepted load |

## Verification
Each serial input passes through two synchronizer flops, and the edge detector compares against one more flop. A serial clock edge is therefore shifted in on the third system clock edge after it arrives. A load enable edge updates the outputs, including the error flag, on the third system clock edge after it rises. The bench holds every serial level for four system clocks, then waits six more clocks after a load before it samples on the falling clock edge, well past the point where the result is due. The bench also samples while load enable is still held high, so that a repeat transfer would show.

// File: rtl/synth_prog_pkg.sv
`timescale 1ns/1ps
package synth_prog_pkg;
  parameter int unsigned DEF_REF_W   = 14;
  parameter int unsigned DEF_SWL_W   = 7;
  parameter int unsigned DEF_MAIN_W  = 11;
  parameter int unsigned DEF_MIN     = 5;
  parameter int unsigned DEF_SYNC    = 2;

  // order matches word bits [REF_W+3:REF_W+1]
  typedef struct packed {
    logic mon_sel;
    logic phase_inv;
    logic psc_sel;
  } ref_flags_t;
endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/1ps
module spi_in_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LANES  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] async_i,
  output logic [LANES-1:0] sync_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_shift_chain.sv
`timescale 1ns/1ps
module spi_shift_chain #(
  parameter int unsigned WORD_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              data_i,
  output logic [WORD_W-1:0] word_o
);
  logic sclk_prev_q;
  logic shift_stb;
  logic [WORD_W-1:0] sr_q;

  assign shift_stb = sclk_i & ~sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      sr_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_i;
      if (shift_stb) sr_q <= {sr_q[WORD_W-2:0], data_i};
    end
  end

  assign word_o = sr_q;

  p_shift_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_stb |=> (word_o[0] == $past(data_i)));
  p_shift_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_stb |=> !shift_stb);
  p_shift_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_stb |=> $stable(word_o));
endmodule

// File: rtl/spi_latch_bank.sv
`timescale 1ns/1ps
module spi_latch_bank
  import synth_prog_pkg::*;
#(
  parameter int unsigned REF_W     = DEF_REF_W,
  parameter int unsigned SWL_W     = DEF_SWL_W,
  parameter int unsigned MAIN_W    = DEF_MAIN_W,
  parameter int unsigned MIN_RATIO = DEF_MIN,
  parameter int unsigned WORD_W    = 1 + SWL_W + MAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [REF_W-1:0]  ref_o,
  output ref_flags_t        flags_o,
  output logic [SWL_W-1:0]  swl_o,
  output logic [MAIN_W-1:0] main_o,
  output logic              err_o
);
  localparam logic [REF_W-1:0]  REF_MIN  = REF_W'(MIN_RATIO);
  localparam logic [MAIN_W-1:0] MAIN_MIN = MAIN_W'(MIN_RATIO);
  localparam int unsigned FLG_LO = REF_W + 1;
  localparam int unsigned FLG_HI = REF_W + 3;

  logic load_prev_q, load_stb, ctl;
  logic [REF_W-1:0]  ref_in;
  logic [SWL_W-1:0]  swl_in;
  logic [MAIN_W-1:0] main_in;
  logic ref_ok, main_ok;

  logic [REF_W-1:0]  ref_q;
  ref_flags_t        flg_q;
  logic [SWL_W-1:0]  swl_q;
  logic [MAIN_W-1:0] main_q;
  logic              err_q;

  assign load_stb = load_i & ~load_prev_q;
  assign ctl      = word_i[0];
  assign ref_in   = word_i[REF_W:1];
  assign swl_in   = word_i[SWL_W:1];
  assign main_in  = word_i[WORD_W-1:SWL_W+1];
  assign ref_ok   = ref_in >= REF_MIN;
  assign main_ok  = main_in >= MAIN_MIN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_prev_q <= 1'b0;
      ref_q       <= REF_MIN;
      flg_q       <= '0;
      swl_q       <= '0;
      main_q      <= MAIN_MIN;
      err_q       <= 1'b0;
    end else begin
      load_prev_q <= load_i;
      if (load_stb) begin
        if (ctl) begin
          if (ref_ok) begin
            ref_q <= ref_in;
            flg_q <= ref_flags_t'(word_i[FLG_HI:FLG_LO]);
          end
          err_q <= ~ref_ok;
        end else begin
          if (main_ok) begin
            swl_q  <= swl_in;
            main_q <= main_in;
          end
          err_q <= ~main_ok;
        end
      end
    end
  end

  assign ref_o   = ref_q;
  assign flags_o = flg_q;
  assign swl_o   = swl_q;
  assign main_o  = main_q;
  assign err_o   = err_q;

  p_ref_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_stb && ctl) |=> ($stable(ref_o) && $stable(flags_o)));
  p_div_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_stb && !ctl) |=> ($stable(swl_o) && $stable(main_o)));
  p_ref_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_stb && ctl && (ref_in < REF_MIN)) |=> ($stable(ref_o) && err_o));
  p_div_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_stb && !ctl && (main_in < MAIN_MIN)) |=> ($stable(main_o) && $stable(swl_o) && err_o));
  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(load_stb));
  p_load_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stb |=> !load_stb);
endmodule

// File: rtl/synth_serial_loader.sv
`timescale 1ns/1ps
module synth_serial_loader
  import synth_prog_pkg::*;
#(
  parameter int unsigned REF_W     = DEF_REF_W,
  parameter int unsigned SWL_W     = DEF_SWL_W,
  parameter int unsigned MAIN_W    = DEF_MAIN_W,
  parameter int unsigned MIN_RATIO = DEF_MIN,
  parameter int unsigned SYNC      = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_load_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic              psc_sel_o,
  output logic              phase_inv_o,
  output logic              mon_sel_o,
  output logic [SWL_W-1:0]  swallow_o,
  output logic [MAIN_W-1:0] main_div_o,
  output logic              cfg_err_o
);
  localparam int unsigned WORD_W = 1 + SWL_W + MAIN_W;

  logic [2:0]        sync_v;
  logic [WORD_W-1:0] word;
  ref_flags_t        flags;

  spi_in_sync #(.STAGES(SYNC), .LANES(3)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ser_load_i, ser_data_i, ser_clk_i}),
    .sync_o  (sync_v)
  );

  spi_shift_chain #(.WORD_W(WORD_W)) i_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sync_v[0]),
    .data_i (sync_v[1]),
    .word_o (word)
  );

  spi_latch_bank #(
    .REF_W(REF_W), .SWL_W(SWL_W), .MAIN_W(MAIN_W),
    .MIN_RATIO(MIN_RATIO), .WORD_W(WORD_W)
  ) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sync_v[2]),
    .word_i  (word),
    .ref_o   (ref_div_o),
    .flags_o (flags),
    .swl_o   (swallow_o),
    .main_o  (main_div_o),
    .err_o   (cfg_err_o)
  );

  assign psc_sel_o   = flags.psc_sel;
  assign phase_inv_o = flags.phase_inv;
  assign mon_sel_o   = flags.mon_sel;

  initial begin
    assert (REF_W + 4 <= WORD_W) else $error("reference fields exceed word");
    assert (SYNC >= 2) else $error("need two synchronizer stages");
  end
endmodule

// File: tb/test_synth_serial_loader.sv
`timescale 1ns/1ps
module test_synth_serial_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [13:0] ref_div;
  logic psc, ph, mon, err;
  logic [6:0] swl;
  logic [10:0] main_div;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  synth_serial_loader i_synth_serial_loader (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata),
    .ser_load_i(sload), .ref_div_o(ref_div), .psc_sel_o(psc),
    .phase_inv_o(ph), .mon_sel_o(mon), .swallow_o(swl),
    .main_div_o(main_div), .cfg_err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mk_ref(input logic [13:0] r, input logic p,
                                          input logic f, input logic m, input logic top);
    return {top, m, f, p, r, 1'b1};
  endfunction

  function automatic logic [18:0] mk_div(input logic [10:0] n, input logic [6:0] a);
    return {n, a, 1'b0};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b;
    wait_clk(4); sclk = 1'b1;
    wait_clk(4); sclk = 1'b0;
  endtask

  task automatic send_word(input logic [18:0] w);
    for (int i = 18; i >= 0; i--) send_bit(w[i]);
    wait_clk(4);
  endtask

  task automatic pulse_load();
    @(negedge clk); sload = 1'b1;
    wait_clk(4); sload = 1'b0;
    wait_clk(6);
  endtask

  task automatic chk_ref(input string req, input int r, input logic p, input logic f, input logic m);
    chk({req, " ref ratio"}, ref_div, r);
    chk({req, " prescaler sel"}, psc, p);
    chk({req, " phase flag"}, ph, f);
    chk({req, " output sel"}, mon, m);
  endtask

  task automatic chk_div(input string req, input int n, input int a);
    chk({req, " main"}, main_div, n);
    chk({req, " swallow"}, swl, a);
  endtask

  task automatic t_reset();
    chk_ref("R6", 5, 0, 0, 0);
    chk_div("R6", 5, 0);
    chk("R6 err", err, 0);
  endtask

  task automatic t_ref_load();
    send_word(mk_ref(14'd12345, 1'b1, 1'b0, 1'b1, 1'b1));
    chk_ref("R2 before load", 5, 0, 0, 0);
    pulse_load();
    chk_ref("R3 R11 R1", 12345, 1, 0, 1);
    chk_div("R5 div untouched", 5, 0);
    chk("R9 err", err, 0);
  endtask

  task automatic t_div_load();
    send_word(mk_div(11'd1000, 7'd100));
    pulse_load();
    chk_div("R4", 1000, 100);
    chk_ref("R5 ref untouched", 12345, 1, 0, 1);
  endtask

  task automatic t_bounds();
    send_word(mk_ref(14'd16383, 1'b0, 1'b1, 1'b0, 1'b0));
    pulse_load();
    chk_ref("R3 full scale", 16383, 0, 1, 0);
    send_word(mk_ref(14'd5, 1'b1, 1'b1, 1'b1, 1'b0));
    pulse_load();
    chk_ref("R7 ratio 5 accepted", 5, 1, 1, 1);
    send_word(mk_div(11'd2047, 7'd127));
    pulse_load();
    chk_div("R8 full scale", 2047, 127);
    send_word(mk_div(11'd5, 7'd0));
    pulse_load();
    chk_div("R8 minimum", 5, 0);
    chk("R9 err after accept", err, 0);
  endtask

  task automatic t_reject();
    send_word(mk_ref(14'd4, 1'b0, 1'b0, 1'b0, 1'b0));
    pulse_load();
    chk_ref("R7 ratio 4 refused", 5, 1, 1, 1);
    chk("R7 err", err, 1);
    send_word(mk_div(11'd4, 7'd50));
    pulse_load();
    chk_div("R8 main 4 refused", 5, 0);
    chk("R8 err", err, 1);
    send_word(mk_ref(14'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    pulse_load();
    chk("R7 ratio 0 refused", ref_div, 5);
    send_word(mk_ref(14'd300, 1'b0, 1'b0, 1'b0, 1'b0));
    pulse_load();
    chk_ref("R9 accepted after refusal", 300, 0, 0, 0);
    chk("R9 err cleared", err, 0);
  endtask

  task automatic t_hold_load();
    send_word(mk_div(11'd600, 7'd7));
    @(negedge clk); sload = 1'b1;
    wait_clk(8);
    chk_div("R2 first edge", 600, 7);
    send_word(mk_div(11'd900, 7'd9));
    wait_clk(8);
    chk_div("R2 level held", 600, 7);
    @(negedge clk); sload = 1'b0;
    wait_clk(8);
    chk_div("R2 falling edge", 600, 7);
    pulse_load();
    chk_div("R2 next rising edge", 900, 9);
  endtask

  task automatic t_long_stream();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_word(mk_div(11'd77, 7'd33));
    pulse_load();
    chk_div("R10 last 19 bits", 77, 33);
    chk_ref("R10 R5 ref untouched", 300, 0, 0, 0);
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_ref_load();
    t_div_load();
    t_bounds();
    t_reject();
    t_hold_load();
    t_long_stream();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule